// File: doc/BRIEF.md
# Dual-Port Inter-Processor Word Mailbox

This block connects two processors, called side A and side B, through two word queues that cross over between them. Each side has a small register port. Software on one side writes a word to its send register, and the word queues up until software on the other side reads its receive register. Each side keeps its own control word, which holds the status of both queues, interrupt enables, a flush trigger, a sticky error flag and a master enable. Each side drives its own interrupt line.

Both sides run on one clock. A register read returns data in the same cycle it is presented, from the state held before the clock edge. A read of the receive register takes the word out of the queue at that edge. A write takes effect at the edge. Each queue holds DEPTH words, 16 by default.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the control word of each side reads 0x0000_0101, which means both queues are empty, every enable is off and the error flag is clear. Both interrupt lines are low.
- R2: While both sides are enabled, words written at offset 0x8 on one side are read back at offset 0xC on the other side in the order they were written. Each read removes one word.
- R3: The control word is at offset 0x4. Bit 0 is 1 when the local send queue is empty and bit 1 is 1 when it holds DEPTH words. Bit 8 is 1 when the local receive queue is empty and bit 9 is 1 when it is full. All four bits are read-only.
- R4: A write to a full send queue is discarded and sets the error flag, bit 14.
- R5: A read of an empty receive queue returns the last word taken from that queue, or 0 if no word has been taken since reset. The queue does not change, and the error flag is set.
- R6: The error flag stays set until software writes the control word with bit 14 set to 1. A control write with bit 14 at 0 leaves the flag unchanged.
- R7: A control write with bit 3 at 1 empties the local send queue, so in the next cycle the peer's bit 8 reads 1. Bit 3 always reads 0, and a control write with bit 3 at 0 leaves the queue unchanged.
- R8: While bit 15 is 0, writes to the send register and reads of the receive register on that side change no queue and do not set the error flag.
- R9: With bit 2 set, the side's interrupt line is high for exactly one cycle, in the cycle after its send queue goes from holding words to empty.
- R10: With bit 10 set, the side's interrupt line is high for one cycle, in the cycle after its receive queue goes from empty to holding words.
- R11: Bits 2, 10 and 15 read back the value last written to them. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_wr | input | 1 | Side A register write strobe |
| a_rd | input | 1 | Side A register read strobe |
| a_addr | input | 4 | Side A byte offset |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data, valid in the same cycle |
| a_irq | output | 1 | Side A interrupt pulse |
| b_wr | input | 1 | Side B register write strobe |
| b_rd | input | 1 | Side B register read strobe |
| b_addr | input | 4 | Side B byte offset |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data, valid in the same cycle |
| b_irq | output | 1 | Side B interrupt pulse |

## Verification
The assertions check the following on every cycle:
- queue occupancy stays within bounds;
- a full queue never accepts a word;
- a flush leaves the queue empty;
- a disabled side never moves a queue;
- the error flag clears only on an acknowledge write;
- each interrupt event lasts a single cycle.

Other behaviour can only be shown by the bench's scenarios:
- word ordering across the two sides;
- the value returned by an empty read;
- the exact cycle in which the peer's status and interrupt change after a push, pop or flush.

The bench checks these against its own queue model, using both random and directed traffic.

// File: rtl/mbx_pkg.sv
// Shared constants for the inter-processor mailbox: register offsets and
// the bit positions of the control word. Assumes 4-bit byte offsets.
package mbx_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_SEND = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RECV = 4'hC;

    localparam int unsigned B_TX_EMPTY = 0;
    localparam int unsigned B_TX_FULL  = 1;
    localparam int unsigned B_IE_TX    = 2;
    localparam int unsigned B_FLUSH    = 3;
    localparam int unsigned B_RX_EMPTY = 8;
    localparam int unsigned B_RX_FULL  = 9;
    localparam int unsigned B_IE_RX    = 10;
    localparam int unsigned B_ERR      = 14;
    localparam int unsigned B_ENABLE   = 15;

    typedef struct packed {
        logic en;
        logic ie_tx;
        logic ie_rx;
        logic err;
    } ctl_t;
endpackage

// File: rtl/mbx_fifo.sv
// Single-clock word queue. A flush takes priority over a push or pop in the
// same cycle. A push into a full queue and a pop from an empty queue are
// dropped. The head word is shown combinationally on dout.
module mbx_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset is needed because cnt guards every read.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);                                              // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);                                              // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);                    // R4
endmodule

// File: rtl/mbx_port.sv
// Register port of one mailbox side. It decodes control, send and receive
// accesses, keeps the control fields and the sticky error flag, and drives
// push, pop and flush into the two queues. It also raises the edge-style
// interrupt. Assumes at most one access per cycle.
module mbx_port
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_flush,
    input  logic              tx_empty,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    input  logic              rx_full
);
    ctl_t              ctl;
    logic [DATA_W-1:0] last_q;
    logic              prev_tx_empty, prev_rx_empty;
    logic              wr_ctrl, wr_send, rd_recv, err_set, err_ack;
    logic              irq_tx_evt, irq_rx_evt;
    logic [DATA_W-1:0] ctrl_word;

    // Access decode and queue strobes.
    assign wr_ctrl  = wr && (addr == OFS_CTRL);
    assign wr_send  = wr && (addr == OFS_SEND);
    assign rd_recv  = rd && (addr == OFS_RECV);
    assign tx_push  = wr_send && ctl.en && !tx_full;
    assign tx_data  = wdata;
    assign tx_flush = wr_ctrl && wdata[B_FLUSH];
    assign rx_pop   = rd_recv && ctl.en && !rx_empty;
    assign err_set  = ctl.en && ((wr_send && tx_full) || (rd_recv && rx_empty));
    assign err_ack  = wr_ctrl && wdata[B_ERR];

    // Control fields: enables follow control writes, error is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl.en    <= wdata[B_ENABLE];
                ctl.ie_tx <= wdata[B_IE_TX];
                ctl.ie_rx <= wdata[B_IE_RX];
            end
            if (err_set)      ctl.err <= 1'b1;
            else if (err_ack) ctl.err <= 1'b0;
        end
    end

    // Last word taken, returned when the receive queue is read empty.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (rx_pop) last_q <= rx_data;
    end

    // Previous-cycle emptiness for edge detection; both queues start empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tx_empty <= 1'b1;
            prev_rx_empty <= 1'b1;
        end else begin
            prev_tx_empty <= tx_empty;
            prev_rx_empty <= rx_empty;
        end
    end

    // Interrupt events from emptiness edges.
    assign irq_tx_evt = ctl.ie_tx && tx_empty && !prev_tx_empty;
    assign irq_rx_evt = ctl.ie_rx && !rx_empty && prev_rx_empty;
    assign irq        = irq_tx_evt || irq_rx_evt;

    // Control word assembly.
    always_comb begin
        ctrl_word             = '0;
        ctrl_word[B_TX_EMPTY] = tx_empty;
        ctrl_word[B_TX_FULL]  = tx_full;
        ctrl_word[B_IE_TX]    = ctl.ie_tx;
        ctrl_word[B_RX_EMPTY] = rx_empty;
        ctrl_word[B_RX_FULL]  = rx_full;
        ctrl_word[B_IE_RX]    = ctl.ie_rx;
        ctrl_word[B_ERR]      = ctl.err;
        ctrl_word[B_ENABLE]   = ctl.en;
    end

    // Read data mux.
    always_comb begin
        case (addr)
            OFS_CTRL: rdata = ctrl_word;
            OFS_RECV: rdata = rx_empty ? last_q : rx_data;
            default:  rdata = '0;
        endcase
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |-> (!tx_push && !rx_pop));                            // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.err && !err_ack) |=> ctl.err);                            // R6
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_push);                                         // R4
    AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_evt |=> !irq_tx_evt);                                   // R9
    AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_evt |=> !irq_rx_evt);                                   // R10
endmodule

// File: rtl/ipc_mailbox.sv
// Two-sided mailbox top. Queue g carries words sent by side g and is read as
// the receive queue of side 1-g. Single clock domain, no bus bridging.
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [3:0]        a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [3:0]        b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);
    localparam int unsigned SIDES = 2;

    logic              s_wr   [SIDES];
    logic              s_rd   [SIDES];
    logic [3:0]        s_addr [SIDES];
    logic [DATA_W-1:0] s_wdata[SIDES];
    logic [DATA_W-1:0] s_rdata[SIDES];
    logic              s_irq  [SIDES];
    logic              q_push [SIDES];
    logic              q_pop  [SIDES];
    logic              q_flush[SIDES];
    logic [DATA_W-1:0] q_din  [SIDES];
    logic [DATA_W-1:0] q_dout [SIDES];
    logic              q_empty[SIDES];
    logic              q_full [SIDES];

    // Map the flat side ports onto indexed arrays.
    assign s_wr[0] = a_wr;       assign s_wr[1] = b_wr;
    assign s_rd[0] = a_rd;       assign s_rd[1] = b_rd;
    assign s_addr[0] = a_addr;   assign s_addr[1] = b_addr;
    assign s_wdata[0] = a_wdata; assign s_wdata[1] = b_wdata;
    assign a_rdata = s_rdata[0]; assign b_rdata = s_rdata[1];
    assign a_irq = s_irq[0];     assign b_irq = s_irq[1];

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .din   (q_din[g]),
            .pop   (q_pop[g]),
            .flush (q_flush[g]),
            .dout  (q_dout[g]),
            .empty (q_empty[g]),
            .full  (q_full[g])
        );

        mbx_port #(.DATA_W(DATA_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (s_wr[g]),
            .rd       (s_rd[g]),
            .addr     (s_addr[g]),
            .wdata    (s_wdata[g]),
            .rdata    (s_rdata[g]),
            .irq      (s_irq[g]),
            .tx_push  (q_push[g]),
            .tx_data  (q_din[g]),
            .tx_flush (q_flush[g]),
            .tx_empty (q_empty[g]),
            .tx_full  (q_full[g]),
            .rx_pop   (q_pop[SIDES-1-g]),
            .rx_data  (q_dout[SIDES-1-g]),
            .rx_empty (q_empty[SIDES-1-g]),
            .rx_full  (q_full[SIDES-1-g])
        );
    end
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ipc_mailbox u0 (.*);

    // Reference model: q0 carries A->B, q1 carries B->A.
    logic [31:0] q0[$], q1[$];
    bit          m_en[2], m_itx[2], m_irx[2], m_err[2];
    logic [31:0] m_last[2];

    function automatic int qsize(int g);
        return (g == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [31:0] qhead(int g);
        return (g == 0) ? q0[0] : q1[0];
    endfunction

    function automatic logic [31:0] exp_ctrl(int s);
        logic [31:0] v = '0;
        v[0]  = (qsize(s) == 0);
        v[1]  = (qsize(s) == DEPTH);
        v[2]  = m_itx[s];
        v[8]  = (qsize(1 - s) == 0);
        v[9]  = (qsize(1 - s) == DEPTH);
        v[10] = m_irx[s];
        v[14] = m_err[s];
        v[15] = m_en[s];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(int s, logic [3:0] addr);
        if (addr == 4'h4) return exp_ctrl(s);
        if (addr == 4'hC) return (qsize(1 - s) == 0) ? m_last[s] : qhead(1 - s);
        return '0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(int s, bit wr, bit rd, logic [3:0] addr, logic [31:0] wd);
        if (s == 0) begin
            a_wr = wr; a_rd = rd; a_addr = addr; a_wdata = wd;
            b_wr = 0;  b_rd = 0;  b_addr = 0;    b_wdata = 0;
        end else begin
            b_wr = wr; b_rd = rd; b_addr = addr; b_wdata = wd;
            a_wr = 0;  a_rd = 0;  a_addr = 0;    a_wdata = 0;
        end
    endtask

    task automatic model_update(int s, bit wr, bit rd, logic [3:0] addr, logic [31:0] wd);
        if (wr && addr == 4'h4) begin
            if (wd[3]) begin
                if (s == 0) q0.delete(); else q1.delete();
            end
            if (wd[14]) m_err[s] = 0;
            m_en[s] = wd[15]; m_itx[s] = wd[2]; m_irx[s] = wd[10];
        end else if (wr && addr == 4'h8 && m_en[s]) begin
            if (qsize(s) == DEPTH) m_err[s] = 1;
            else if (s == 0) q0.push_back(wd);
            else q1.push_back(wd);
        end else if (rd && addr == 4'hC && m_en[s]) begin
            if (qsize(1 - s) == 0) m_err[s] = 1;
            else if (s == 0) m_last[0] = q1.pop_front();
            else m_last[1] = q0.pop_front();
        end
    endtask

    // One access on side s; checks read data before the edge and irq after.
    task automatic op(int s, bit wr, bit rd, logic [3:0] addr, logic [31:0] wd, string tag);
        bit pre_e[2];
        bit now_e[2];
        bit exp_irq;
        @(negedge clk);
        drive(s, wr, rd, addr, wd);
        #1;
        if (rd) chk(tag, (s == 0) ? a_rdata : b_rdata, exp_read(s, addr));
        pre_e[0] = (q0.size() == 0);
        pre_e[1] = (q1.size() == 0);
        @(posedge clk);
        model_update(s, wr, rd, addr, wd);
        #1;
        now_e[0] = (q0.size() == 0);
        now_e[1] = (q1.size() == 0);
        for (int k = 0; k < 2; k++) begin
            exp_irq = (m_itx[k] && now_e[k] && !pre_e[k]) ||
                      (m_irx[k] && !now_e[1-k] && pre_e[1-k]);
            chk("R9 R10 irq", {31'b0, (k == 0) ? a_irq : b_irq}, {31'b0, exp_irq});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int          pick;
        int          side;
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 2; k++) begin
            m_en[k] = 0; m_itx[k] = 0; m_irx[k] = 0; m_err[k] = 0; m_last[k] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 a_irq", {31'b0, a_irq}, 32'h0);
        op(0, 0, 1, 4'h4, 0, "R1 ctrl A");
        op(1, 0, 1, 4'h4, 0, "R1 ctrl B");
        chk("R1 ctrl value", exp_ctrl(0), 32'h0000_0101);

        // R11: enables read back
        op(0, 1, 0, 4'h4, 32'h0000_8404, "R11");
        op(0, 0, 1, 4'h4, 0, "R11 ctrl A");
        op(1, 1, 0, 4'h4, 32'h0000_8400, "R11");
        op(1, 0, 1, 4'h4, 0, "R11 ctrl B");

        // R2 R3 R4 R10: fill A->B, overflow
        for (int i = 0; i < DEPTH; i++) op(0, 1, 0, 4'h8, 32'hA000_0000 + i, "R2");
        op(0, 0, 1, 4'h4, 0, "R3 full A");
        op(1, 0, 1, 4'h4, 0, "R3 full B");
        op(0, 1, 0, 4'h8, 32'hDEAD_BEEF, "R4");
        op(0, 0, 1, 4'h4, 0, "R4 err A");

        // R2 R5 R9: drain, then read empty
        for (int i = 0; i < DEPTH; i++) op(1, 0, 1, 4'hC, 0, "R2 order");
        op(1, 0, 1, 4'hC, 0, "R5 empty read");
        op(1, 0, 1, 4'h4, 0, "R5 err B");

        // R6: write 0 to error keeps it, write 1 clears
        op(1, 1, 0, 4'h4, 32'h0000_8000, "R6");
        op(1, 0, 1, 4'h4, 0, "R6 kept");
        op(1, 1, 0, 4'h4, 32'h0000_C000, "R6");
        op(1, 0, 1, 4'h4, 0, "R6 cleared");

        // R7: flush empties, bit3=0 does not
        for (int i = 0; i < 3; i++) op(0, 1, 0, 4'h8, 32'h7700_0000 + i, "R7");
        op(0, 1, 0, 4'h4, 32'h0000_8404, "R7");
        op(1, 0, 1, 4'h4, 0, "R7 not flushed");
        op(0, 1, 0, 4'h4, 32'h0000_8408, "R7");
        op(1, 0, 1, 4'h4, 0, "R7 peer empty");
        op(0, 0, 1, 4'h4, 0, "R7 bit3 reads 0");

        // R8: disabled side ignores push and pop
        op(0, 1, 0, 4'h4, 32'h0000_0000, "R8");
        op(0, 1, 0, 4'h8, 32'h1234_5678, "R8");
        op(1, 0, 1, 4'h4, 0, "R8 no push");
        op(0, 0, 1, 4'hC, 0, "R8 read");
        op(0, 0, 1, 4'h4, 0, "R8 no err");
        op(0, 1, 0, 4'h4, 32'h0000_8004, "R8");
        op(1, 1, 0, 4'h8, 32'h0BAD_0001, "R8");
        op(1, 1, 0, 4'h4, 32'h0000_0400, "R8");
        op(1, 0, 1, 4'hC, 0, "R8 disabled pop");
        op(0, 0, 1, 4'h4, 0, "R8 q1 kept");
        op(1, 1, 0, 4'h4, 32'h0000_8400, "R8");

        // Constrained random mix on both sides
        for (int i = 0; i < 4000; i++) begin
            side = $urandom_range(0, 1);
            pick = $urandom_range(0, 99);
            if (pick < 40) op(side, 1, 0, 4'h8, $urandom, "R2 rnd send");
            else if (pick < 75) op(side, 0, 1, 4'hC, 0, "R2 rnd recv");
            else if (pick < 87) op(side, 0, 1, 4'h4, 0, "R3 rnd ctrl");
            else if (pick < 95) begin
                w = $urandom;
                w[15] = ($urandom_range(0, 9) != 0);
                w[3]  = ($urandom_range(0, 7) == 0);
                op(side, 1, 0, 4'h4, w, "R11 rnd ctrl wr");
            end else op(side, 0, 0, 4'h0, 0, "idle");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule